// File: doc/BRIEF.md
# Event Fragment Generator

This block stands in for a detector front-end when a readout link is under test. A small descriptor store is filled through a plain write port. Each entry gives an event identifier, a bunch-crossing number, a source number, a payload length in bytes and a pause that must follow the event. When `start` is pulsed, the generator walks the first `num_desc` entries in index order. For each entry it sends one framed fragment on a 64-bit valid/ready stream. The fragment is a header word, then the payload words, then a trailer word. Between fragments it keeps the stream quiet for the programmed pause.

The pause is counted in 100 ns units. A prescaler turns each unit into `TICK_CYC` clock cycles. The default of 10 gives exact units at 100 MHz, and a different value can approximate them at other clock rates. Payload words follow a counting pattern keyed to the event identifier, so a receiver can check both content and length. After the last selected entry the generator stops and holds `done` until the next `start`.

Top module: `evgen_top`

## Requirements
- R1: While reset is asserted, and after it is released until `start` is pulsed, `out_valid` and `done` are 0.
- R2: The first word of each fragment has `out_sop`=1 and is laid out as bits[63:56]=0xA5, [55:32]=event id, [31:20]=bunch-crossing, [19:8]=source, [7:0]=0.
- R3: A fragment carries exactly ceil(size_bytes/8) payload words. Payload word k (k counted from 0) is laid out as [63:40]=event id, [39:32]=0, [31:0]=k.
- R4: The last word of each fragment has `out_eop`=1 and is laid out as [63:56]=0x5A, [55:32]=event id, [31:8]=payload words+2, [7:0]=0.
- R5: A descriptor with size 0 produces a header followed directly by a trailer whose count field is 2.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values on the next cycle, and no word is skipped.
- R7: Between the cycle in which a trailer is accepted and the cycle in which the next header is first valid, `out_valid` is 0 for exactly gap×TICK_CYC+1 cycles, where gap is the pause field of the event just sent.
- R8: Descriptors 0 to N-1 are sent in index order, and nothing else is sent. After the last trailer is accepted, `done` goes to 1 and stays at 1, with `out_valid`=0, until `start`.
- R9: `num_desc`=0 raises `done` without sending any word. A value above DEPTH is treated as DEPTH.
- R10: A `start` pulse while fragments are being sent or a pause is running has no effect.
- R11: A `start` pulse while `done`=1 sends the sequence again from descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse to begin a run of descriptors |
| num_desc | input | IDX_W+1 | Number of descriptors to run, sampled at start |
| wr_en | input | 1 | Descriptor write strobe |
| wr_addr | input | IDX_W | Descriptor index to write |
| wr_event_id | input | 24 | Event identifier field |
| wr_size | input | 16 | Payload length in bytes |
| wr_bx | input | 12 | Bunch-crossing field |
| wr_src | input | 12 | Source number field |
| wr_gap | input | 16 | Pause after the event, in 100 ns units |
| out_data | output | 64 | Fragment word |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Sink accepts word |
| out_sop | output | 1 | Word is a header |
| out_eop | output | 1 | Word is a trailer |
| done | output | 1 | Run finished |

## Verification
The bench targets sizes that are not multiples of eight and zero-length fragments. A design that rounds down or drops the empty payload case would send a short fragment or stall after the header. It measures each pause to the exact cycle, with pauses of 0 to 3 units. A timer that is off by one, or that starts before the trailer is accepted, would show the wrong number of idle cycles. An irregular ready pattern checks that a held word is neither changed nor lost. The bench also pulses `start` in the middle of a run, and a design that restarted would send a duplicated sequence. Runs with zero descriptors and with more than DEPTH descriptors check the count limits, and a second pulse after `done` checks that the run restarts from descriptor 0.

// File: rtl/evgen_pkg.sv
package evgen_pkg;

  localparam int unsigned ID_W   = 24;
  localparam int unsigned BX_W   = 12;
  localparam int unsigned SRC_W  = 12;
  localparam int unsigned SIZE_W = 16;
  localparam int unsigned GAP_W  = 16;
  localparam int unsigned PW_W   = SIZE_W - 2;

  localparam logic [7:0] HDR_TAG = 8'hA5;
  localparam logic [7:0] TRL_TAG = 8'h5A;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [SIZE_W-1:0] size;
    logic [BX_W-1:0]   bx;
    logic [SRC_W-1:0]  src;
    logic [GAP_W-1:0]  gap;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HDR,
    ST_PAY,
    ST_TRL,
    ST_GAP,
    ST_DONE
  } gen_state_e;

  // bytes rounded up to whole 64-bit words
  function automatic logic [PW_W-1:0] payload_words(input logic [SIZE_W-1:0] nbytes);
    logic [SIZE_W:0] sum;
    sum = {1'b0, nbytes} + (SIZE_W+1)'(7);
    return sum[SIZE_W:3];
  endfunction

  function automatic logic [63:0] make_header(input logic [ID_W-1:0] id,
                                              input logic [BX_W-1:0] bx,
                                              input logic [SRC_W-1:0] src);
    return {HDR_TAG, id, bx, src, 8'h00};
  endfunction

  function automatic logic [63:0] make_payload(input logic [ID_W-1:0] id,
                                               input logic [PW_W-1:0] beat);
    return {id, 8'h00, 32'(beat)};
  endfunction

  function automatic logic [63:0] make_trailer(input logic [ID_W-1:0] id,
                                               input logic [PW_W-1:0] nwords);
    return {TRL_TAG, id, 24'(nwords) + 24'd2, 8'h00};
  endfunction

endpackage

// File: rtl/evgen_rst_sync.sv
module evgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/evgen_desc_mem.sv
module evgen_desc_mem
  import evgen_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  desc_t            wr_desc,
  input  logic [IDX_W-1:0] rd_addr,
  output desc_t            rd_desc
);

  desc_t mem_q [DEPTH];

  // one enabled register bank per entry; no reset on the storage
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en && (wr_addr == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        mem_q[i] <= wr_desc;
      end
    end
  end

  always_comb begin
    rd_desc = mem_q[0];
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_addr == IDX_W'(j)) begin
        rd_desc = mem_q[j];
      end
    end
  end

endmodule

// File: rtl/evgen_tick.sv
module evgen_tick #(
  parameter int unsigned TICK_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  if (TICK_CYC <= 1) begin : g_direct
    assign tick = run;
  end else begin : g_count
    localparam int unsigned CNT_W = $clog2(TICK_CYC);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICK_CYC - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_max;

    assign at_max = (cnt_q == CNT_MAX);
    assign tick   = run && at_max;

    always_comb begin
      if (!run || at_max) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/evgen_framer.sv
module evgen_framer
  import evgen_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NUM_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num_desc,
  output logic [IDX_W-1:0] rd_addr,
  input  desc_t            rd_desc,
  input  logic             tick,
  output logic             tick_run,
  output logic [63:0]      out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sop,
  output logic             out_eop,
  output logic             done
);

  localparam logic [NUM_W-1:0] NUM_MAX = NUM_W'(DEPTH);

  gen_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [ID_W-1:0]   id_q;
  logic [BX_W-1:0]   bx_q;
  logic [SRC_W-1:0]  src_q;
  logic [GAP_W-1:0]  gap_q;
  logic [PW_W-1:0]   pw_q;
  logic [PW_W-1:0]   beat_q, beat_d;
  logic [GAP_W-1:0]  units_q, units_d;

  logic              desc_en;
  logic              hs;
  logic              is_last;
  logic [NUM_W-1:0]  num_clamped;

  assign hs          = out_valid && out_ready;
  assign desc_en     = (state_q == ST_LOAD);
  assign is_last     = ({1'b0, idx_q} + NUM_W'(1)) == num_q;
  assign num_clamped = (num_desc > NUM_MAX) ? NUM_MAX : num_desc;
  assign rd_addr     = idx_q;
  assign tick_run    = (state_q == ST_GAP);

  // next state and counters
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    num_d   = num_q;
    beat_d  = beat_q;
    units_d = units_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          idx_d   = '0;
          num_d   = num_clamped;
          state_d = (num_clamped == '0) ? ST_DONE : ST_LOAD;
        end
      end
      ST_LOAD: begin
        beat_d  = '0;
        state_d = ST_HDR;
      end
      ST_HDR: begin
        if (hs) begin
          state_d = (pw_q == '0) ? ST_TRL : ST_PAY;
        end
      end
      ST_PAY: begin
        if (hs) begin
          beat_d = beat_q + PW_W'(1);
          if (beat_q == pw_q - PW_W'(1)) begin
            state_d = ST_TRL;
          end
        end
      end
      ST_TRL: begin
        if (hs) begin
          if (is_last) begin
            state_d = ST_DONE;
          end else if (gap_q == '0) begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_LOAD;
          end else begin
            units_d = gap_q;
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          units_d = units_q - GAP_W'(1);
          if (units_q == GAP_W'(1)) begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      num_q   <= '0;
      beat_q  <= '0;
      units_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      num_q   <= num_d;
      beat_q  <= beat_d;
      units_q <= units_d;
    end
  end

  // descriptor fields captured once per event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      bx_q  <= '0;
      src_q <= '0;
      gap_q <= '0;
      pw_q  <= '0;
    end else if (desc_en) begin
      id_q  <= rd_desc.id;
      bx_q  <= rd_desc.bx;
      src_q <= rd_desc.src;
      gap_q <= rd_desc.gap;
      pw_q  <= payload_words(rd_desc.size);
    end
  end

  // output word select
  always_comb begin
    out_valid = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    out_data  = '0;
    unique case (state_q)
      ST_HDR: begin
        out_valid = 1'b1;
        out_sop   = 1'b1;
        out_data  = make_header(id_q, bx_q, src_q);
      end
      ST_PAY: begin
        out_valid = 1'b1;
        out_data  = make_payload(id_q, beat_q);
      end
      ST_TRL: begin
        out_valid = 1'b1;
        out_eop   = 1'b1;
        out_data  = make_trailer(id_q, pw_q);
      end
      default: ;
    endcase
  end

  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/evgen_top.sv
module evgen_top
  import evgen_pkg::*;
#(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned TICK_CYC = 10,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NUM_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_W-1:0]  num_desc,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [ID_W-1:0]   wr_event_id,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [BX_W-1:0]   wr_bx,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [GAP_W-1:0]  wr_gap,
  output logic [63:0]       out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic              done
);

  logic             rst_n_s;
  desc_t            wr_desc;
  desc_t            rd_desc;
  logic [IDX_W-1:0] rd_addr;
  logic             tick_run;
  logic             tick;

  assign wr_desc = '{id: wr_event_id, size: wr_size, bx: wr_bx, src: wr_src, gap: wr_gap};

  evgen_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  evgen_desc_mem #(.DEPTH(DEPTH)) i_desc_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_desc (wr_desc),
    .rd_addr (rd_addr),
    .rd_desc (rd_desc)
  );

  evgen_tick #(.TICK_CYC(TICK_CYC)) i_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (tick_run),
    .tick  (tick)
  );

  evgen_framer #(.DEPTH(DEPTH)) i_framer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .num_desc  (num_desc),
    .rd_addr   (rd_addr),
    .rd_desc   (rd_desc),
    .tick      (tick),
    .tick_run  (tick_run),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .done      (done)
  );

endmodule

// File: rtl/evgen_checker.sv
module evgen_checker
  import evgen_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_sop,
  input logic        out_eop,
  input logic        done
);

  logic            in_frame_q;
  logic [ID_W-1:0] hdr_id_q;
  logic [31:0]     pay_cnt_q;
  logic            hs;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      hdr_id_q   <= '0;
      pay_cnt_q  <= '0;
    end else if (hs) begin
      if (out_sop) begin
        in_frame_q <= 1'b1;
        hdr_id_q   <= out_data[55:32];
        pay_cnt_q  <= '0;
      end else if (out_eop) begin
        in_frame_q <= 1'b0;
      end else begin
        pay_cnt_q  <= pay_cnt_q + 32'd1;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  p_hdr_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data[63:56] == HDR_TAG && out_data[7:0] == 8'h00);

  p_hdr_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !in_frame_q && !out_eop);

  p_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> in_frame_q);

  p_pay_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop && !out_eop |-> out_data[63:40] == hdr_id_q && out_data[39:32] == 8'h00 && out_data[31:0] == pay_cnt_q);

  p_trl_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> out_data[63:56] == TRL_TAG && out_data[55:32] == hdr_id_q && out_data[31:8] == pay_cnt_q[23:0] + 24'd2);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

endmodule

bind evgen_top evgen_checker i_evgen_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .done      (done)
);

// File: tb/test_evgen_top.sv
module test_evgen_top;

  localparam int DEPTH = 16;
  localparam int TICK  = 10;
  localparam int IDX_W = 4;
  localparam int NUM_W = 5;
  localparam int NVEC  = 6;
  localparam int LOGSZ = 1024;

  // {id, size bytes, bx, src, gap}
  localparam logic [79:0] TAB [NVEC] = '{
    {24'h000101, 16'd24, 12'h123, 12'h045, 16'd2},
    {24'h000202, 16'd0,  12'h001, 12'h002, 16'd0},
    {24'h000303, 16'd1,  12'hFFF, 12'h7A0, 16'd1},
    {24'hABCDEF, 16'd17, 12'h456, 12'h0C3, 16'd0},
    {24'h000505, 16'd64, 12'h800, 12'h001, 16'd3},
    {24'hFFFFFF, 16'd8,  12'h00F, 12'hFFF, 16'd1}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [NUM_W-1:0]  num_desc;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [23:0]       wr_event_id;
  logic [15:0]       wr_size;
  logic [11:0]       wr_bx;
  logic [11:0]       wr_src;
  logic [15:0]       wr_gap;
  logic [63:0]       out_data;
  logic              out_valid;
  logic              out_ready;
  logic              out_sop;
  logic              out_eop;
  logic              done;

  int n_chk;
  int n_fail;
  int cyc;
  int rdy_mode;
  logic [15:0] lfsr;

  logic [63:0] log_data [LOGSZ];
  logic        log_sop  [LOGSZ];
  logic        log_eop  [LOGSZ];
  int          log_cyc  [LOGSZ];
  int          log_n;
  logic        log_clr;

  logic [23:0] e_id   [DEPTH];
  logic [15:0] e_size [DEPTH];
  logic [11:0] e_bx   [DEPTH];
  logic [11:0] e_src  [DEPTH];
  logic [15:0] e_gap  [DEPTH];

  logic        stall_prev;
  logic [63:0] data_prev;

  evgen_top #(.DEPTH(DEPTH), .TICK_CYC(TICK)) i_evgen_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .num_desc    (num_desc),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_event_id (wr_event_id),
    .wr_size     (wr_size),
    .wr_bx       (wr_bx),
    .wr_src      (wr_src),
    .wr_gap      (wr_gap),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .done        (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // sink ready driver, changes just after the rising edge
  initial begin
    out_ready = 1'b1;
    lfsr      = 16'hACE1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rdy_mode == 0) out_ready = 1'b1;
      else               out_ready = lfsr[0] | lfsr[3];
    end
  end

  // monitor: samples between edges, logs words that the next edge accepts
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (log_clr) begin
      log_n = 0;
    end else if (rst_n) begin
      if (stall_prev) begin
        n_chk = n_chk + 1;
        if (!(out_valid && out_data === data_prev)) begin
          n_fail = n_fail + 1;
          $display("FAIL R6 held word: actual valid=%0b data=%h expected valid=1 data=%h",
                   out_valid, out_data, data_prev);
        end
      end
      if (out_valid && out_ready && log_n < LOGSZ) begin
        log_data[log_n] = out_data;
        log_sop[log_n]  = out_sop;
        log_eop[log_n]  = out_eop;
        log_cyc[log_n]  = cyc;
        log_n = log_n + 1;
      end
    end
    stall_prev = rst_n && out_valid && !out_ready;
    data_prev  = out_data;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk); #1 log_clr = 1'b1;
    @(posedge clk); #1 log_clr = 1'b0;
  endtask

  task automatic write_desc(input int a, input logic [23:0] id, input logic [15:0] sz,
                            input logic [11:0] bx, input logic [11:0] src, input logic [15:0] gp);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = IDX_W'(a);
    wr_event_id = id; wr_size = sz; wr_bx = bx; wr_src = src; wr_gap = gp;
    e_id[a] = id; e_size[a] = sz; e_bx[a] = bx; e_src[a] = src; e_gap[a] = gp;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic pulse_start(input int n);
    @(posedge clk); #1 start = 1'b1; num_desc = NUM_W'(n);
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) return;
    end
    n_chk = n_chk + 1; n_fail = n_fail + 1;
    $display("FAIL R8 done not reached: actual 0 expected 1");
  endtask

  // compare the logged stream with what the descriptors call for
  task automatic verify(input int n_ev, input bit timed);
    int p = 0;
    int prev_trl = 0;
    for (int e = 0; e < n_ev; e++) begin
      int pw = (int'(e_size[e]) + 7) / 8;
      if (p >= LOGSZ - 2 - pw) break;
      chk("R2 header word", log_data[p], {8'hA5, e_id[e], e_bx[e], e_src[e], 8'h00});
      chk("R2 header sop",  64'(log_sop[p]), 64'd1);
      if (timed && e > 0)
        chk("R7 idle cycles", 64'(log_cyc[p] - prev_trl - 1), 64'(int'(e_gap[e-1]) * TICK + 1));
      p++;
      for (int k = 0; k < pw; k++) begin
        chk("R3 payload word", log_data[p], {e_id[e], 8'h00, 32'(k)});
        p++;
      end
      chk(pw == 0 ? "R5 empty trailer" : "R4 trailer word", log_data[p],
          {8'h5A, e_id[e], 24'(pw + 2), 8'h00});
      chk("R4 trailer eop", 64'(log_eop[p]), 64'd1);
      prev_trl = log_cyc[p];
      p++;
    end
    chk("R8 word total", 64'(log_n), 64'(p));
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; rdy_mode = 0;
    log_n = 0; log_clr = 1'b0; stall_prev = 1'b0; data_prev = '0;
    rst_n = 1'b0; start = 1'b0; num_desc = '0;
    wr_en = 1'b0; wr_addr = '0; wr_event_id = '0; wr_size = '0;
    wr_bx = '0; wr_src = '0; wr_gap = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 done in reset",  64'(done), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    chk("R1 done after reset",  64'(done), 64'd0);

    // R9: zero descriptors
    pulse_start(0);
    repeat (3) @(negedge clk);
    chk("R9 zero count done", 64'(done), 64'd1);
    chk("R9 zero count words", 64'(log_n), 64'd0);

    // vector table: load then run with a free sink
    for (int i = 0; i < NVEC; i++)
      write_desc(i, TAB[i][79:56], TAB[i][55:40], TAB[i][39:28], TAB[i][27:16], TAB[i][15:0]);
    clear_log();
    pulse_start(NVEC);
    repeat (15) @(posedge clk);
    pulse_start(2);             // R10: ignored mid-run
    wait_done(2000);
    verify(NVEC, 1'b1);         // covers R2 R3 R4 R5 R7 R8 R10
    repeat (6) @(negedge clk);
    chk("R8 done held", 64'(done), 64'd1);
    chk("R8 no words after done", 64'(out_valid), 64'd0);

    // R11 restart from done, R6 with an irregular sink
    clear_log();
    rdy_mode = 1;
    pulse_start(NVEC);
    wait_done(4000);
    chk("R11 first header id", 64'(log_data[0][55:32]), 64'(TAB[0][79:56]));
    verify(NVEC, 1'b0);
    rdy_mode = 0;

    // R9: count above depth is clamped
    for (int i = 0; i < DEPTH; i++)
      write_desc(i, 24'h100 + 24'(i), 16'(i % 3 * 9), 12'(i), 12'(15 - i), 16'd0);
    clear_log();
    pulse_start(DEPTH + 4);
    wait_done(4000);
    verify(DEPTH, 1'b1);
    chk("R9 clamp done", 64'(done), 64'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk = n_chk + 1; n_fail = n_fail + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule